// File: doc/BRIEF.md
# Dual-Axis Frozen Position Latch Byte Reader

This block sits between two 32-bit position counters and an 8-bit host read port. Each axis owns a position latch that follows its counter on every rising clock edge. A host reads one 32-bit value as four bytes, most significant byte first. The read is coherent because the latch of the axis being read is frozen for the whole read.

On the falling clock edge, a control stage samples the active-low output enable, the two byte-select inputs and the axis select. It sets a per-axis freeze flag when a read starts and clears the flags once the enable is seen high again. The byte multiplexer is purely combinational, so the selected byte follows the select and axis inputs at once.

The block provides the output byte and a drive-enable signal. A pad wrapper outside the block turns these into tri-state pins. The counters' own count, direction and carry outputs never pass through this block, so freezing a latch cannot affect them.

Top module: `qpl_latch_reader`

## Requirements
- R1: While an axis reset `rst_n[i]` is low, that axis's latch reads as all zeros and its freeze flag is clear.
- R2: While its freeze flag is clear, an axis latch takes the value of `cnt_pos[i]` at each rising clock edge. The value is visible right after that edge.
- R3: The byte-select code `{sel_a, sel_b}` picks one latch byte. 2'b01 gives bits 31:24, 2'b11 gives bits 23:16, 2'b00 gives bits 15:8 and 2'b10 gives bits 7:0.
- R4: A falling edge that samples `oe_n` low with code 2'b01 sets the freeze flag of the axis then selected by `axis_sel`. From the next rising edge on, that latch stops loading.
- R5: Starting a read on one axis does not freeze the other axis. Its latch keeps following its counter.
- R6: A falling edge that samples `oe_n` high clears every freeze flag. The next rising edge reloads the latch with the current counter value.
- R7: `oe_n` low with a select code other than 2'b01 does not start a freeze.
- R8: `rd_drive` is high exactly while `oe_n` is low. `rd_data` follows `axis_sel` (0 = first axis, 1 = second axis) and the select code with no clock edge in between.
- R9: An axis reset acts without a clock, clears only its own axis, and removes a freeze in progress on that axis.
- R10: While an axis is frozen, changing the select code or the axis select does not release it. Only `oe_n` sampled high does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Latches load on the rising edge; the controls are sampled on the falling edge |
| rst_n | input | AXES | Asynchronous active-low reset, one bit per axis |
| cnt_pos | input | AXES x POS_W | Counter value of each axis |
| oe_n | input | 1 | Active-low read enable |
| sel_a | input | 1 | High bit of the byte-select code |
| sel_b | input | 1 | Low bit of the byte-select code |
| axis_sel | input | AXIS_W | Axis to read: 0 for the first, 1 for the second |
| rd_data | output | BYTE_W | Selected latch byte |
| rd_drive | output | 1 | Pad drive enable: high means drive `rd_data` |

## Verification
A counter value applied before rising edge P appears on `rd_data` just after P, one register away. A control change made after rising edge P is sampled at the falling edge that follows. It then freezes or releases the latch at rising edge P+1, so its effect is checked just after P+1.

Select, axis and enable changes pass through no register. The bench checks them within the same cycle, and resets are checked one time unit after the reset pin falls. All inputs are driven two time units after a rising edge, and outputs are sampled one time unit after a rising edge. This keeps every check clear of both clock edges.

// File: rtl/qpl_pkg.sv
package qpl_pkg;

  // Byte-select code {sel_a, sel_b}; the encoding is fixed by the host read order.
  typedef enum logic [1:0] {
    BSEL_THIRD  = 2'b00,
    BSEL_MSB    = 2'b01,
    BSEL_LSB    = 2'b10,
    BSEL_SECOND = 2'b11
  } bsel_e;

  // Byte lane index (0 = least significant) addressed by a select code.
  function automatic logic [1:0] lane_of(input bsel_e code);
    logic [1:0] lane;
    case (code)
      BSEL_MSB:    lane = 2'd3;
      BSEL_SECOND: lane = 2'd2;
      BSEL_THIRD:  lane = 2'd1;
      default:     lane = 2'd0;
    endcase
    return lane;
  endfunction

  // True when the sampled controls open a frozen read.
  function automatic logic opens_read(input logic oe_n, input bsel_e code);
    return (!oe_n) && (code == BSEL_MSB);
  endfunction

endpackage

// File: rtl/qpl_freeze_ctl.sv
module qpl_freeze_ctl
  import qpl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  oe_n,
  input  bsel_e code,
  input  logic  axis_hit,
  output logic  freeze_q,
  output logic  start_ev,
  output logic  release_ev
);

  assign start_ev   = opens_read(oe_n, code) && axis_hit;
  assign release_ev = oe_n;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      freeze_q <= 1'b0;
    else if (release_ev)
      freeze_q <= 1'b0;
    else if (start_ev)
      freeze_q <= 1'b1;
  end

endmodule

// File: rtl/qpl_pos_latch.sv
module qpl_pos_latch #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [POS_W-1:0] cnt,
  output logic [POS_W-1:0] lat_q,
  output logic             load_ev
);

  assign load_ev = !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lat_q <= '0;
    else if (load_ev)
      lat_q <= cnt;
  end

endmodule

// File: rtl/qpl_byte_mux.sv
module qpl_byte_mux
  import qpl_pkg::*;
#(
  parameter int AXES   = 2,
  parameter int POS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int AXIS_W = (AXES > 1) ? $clog2(AXES) : 1
) (
  input  logic [AXES-1:0][POS_W-1:0] lat,
  input  logic [AXIS_W-1:0]          axis_sel,
  input  bsel_e                      code,
  output logic [BYTE_W-1:0]          byte_q
);

  localparam int LANES = POS_W / BYTE_W;

  logic [POS_W-1:0] word;
  logic [1:0]       lane;
  logic [LANES-1:0][BYTE_W-1:0] split;

  assign word  = lat[axis_sel];
  assign lane  = lane_of(code);
  assign split = word;

  always_comb begin
    byte_q = '0;
    for (int k = 0; k < LANES; k++)
      if (lane == k[1:0]) byte_q = split[k];
  end

endmodule

// File: rtl/qpl_latch_reader.sv
module qpl_latch_reader
  import qpl_pkg::*;
#(
  parameter int AXES   = 2,
  parameter int POS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int AXIS_W = (AXES > 1) ? $clog2(AXES) : 1
) (
  input  logic                       clk,
  input  logic [AXES-1:0]            rst_n,
  input  logic [AXES-1:0][POS_W-1:0] cnt_pos,
  input  logic                       oe_n,
  input  logic                       sel_a,
  input  logic                       sel_b,
  input  logic [AXIS_W-1:0]          axis_sel,
  output logic [BYTE_W-1:0]          rd_data,
  output logic                       rd_drive
);

  bsel_e code;
  assign code = bsel_e'({sel_a, sel_b});

  logic [AXES-1:0]            freeze_q;
  logic [AXES-1:0]            start_ev;
  logic [AXES-1:0]            release_ev;
  logic [AXES-1:0]            load_ev;
  logic [AXES-1:0][POS_W-1:0] lat_q;

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    qpl_freeze_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n[i]),
      .oe_n       (oe_n),
      .code       (code),
      .axis_hit   (axis_sel == i[AXIS_W-1:0]),
      .freeze_q   (freeze_q[i]),
      .start_ev   (start_ev[i]),
      .release_ev (release_ev[i])
    );

    qpl_pos_latch #(.POS_W(POS_W)) u_lat (
      .clk     (clk),
      .rst_n   (rst_n[i]),
      .freeze  (freeze_q[i]),
      .cnt     (cnt_pos[i]),
      .lat_q   (lat_q[i]),
      .load_ev (load_ev[i])
    );
  end

  qpl_byte_mux #(.AXES(AXES), .POS_W(POS_W), .BYTE_W(BYTE_W)) u_mux (
    .lat      (lat_q),
    .axis_sel (axis_sel),
    .code     (code),
    .byte_q   (rd_data)
  );

  assign rd_drive = !oe_n;

endmodule

// File: rtl/qpl_latch_reader_chk.sv
module qpl_latch_reader_chk #(
  parameter int AXES   = 2,
  parameter int POS_W  = 32,
  parameter int BYTE_W = 8,
  localparam int AXIS_W = (AXES > 1) ? $clog2(AXES) : 1
) (
  input logic                       clk,
  input logic [AXES-1:0]            rst_n,
  input logic [AXES-1:0][POS_W-1:0] cnt_pos,
  input logic                       oe_n,
  input logic                       sel_a,
  input logic                       sel_b,
  input logic [AXIS_W-1:0]          axis_sel,
  input logic [BYTE_W-1:0]          rd_data,
  input logic [AXES-1:0]            freeze_q,
  input logic [AXES-1:0][POS_W-1:0] lat_q
);

  for (genvar i = 0; i < AXES; i++) begin : g_ax
    // R2: unfrozen latch takes the counter value
    p_track_r2: assert property (@(posedge clk) disable iff (!rst_n[i])
      !freeze_q[i] |=> lat_q[i] == $past(cnt_pos[i]));
    // R4: frozen latch keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n[i])
      freeze_q[i] |=> $stable(lat_q[i]));
    // R4: a sampled read start on this axis raises its flag
    p_start_r4: assert property (@(negedge clk) disable iff (!rst_n[i])
      (!oe_n && !sel_a && sel_b && axis_sel == i[AXIS_W-1:0]) |=> freeze_q[i]);
    // R6: enable seen high drops the flag
    p_release_r6: assert property (@(negedge clk) disable iff (!rst_n[i])
      oe_n |=> !freeze_q[i]);
    // R7: enable low with a non-MSB code never raises a clear flag
    p_nostart_r7: assert property (@(negedge clk) disable iff (!rst_n[i])
      (!oe_n && !(!sel_a && sel_b) && !freeze_q[i]) |=> !freeze_q[i]);
  end

  // R3: byte lane {sel_b, ~sel_a} of the selected latch
  logic [POS_W-1:0] shifted;
  always_comb begin
    shifted = lat_q[axis_sel] >> (BYTE_W * {sel_b, ~sel_a});
    a_mux_r3: assert (rd_data == shifted[BYTE_W-1:0]);
  end

endmodule

bind qpl_latch_reader qpl_latch_reader_chk #(
  .AXES(AXES), .POS_W(POS_W), .BYTE_W(BYTE_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_pos  (cnt_pos),
  .oe_n     (oe_n),
  .sel_a    (sel_a),
  .sel_b    (sel_b),
  .axis_sel (axis_sel),
  .rd_data  (rd_data),
  .freeze_q (freeze_q),
  .lat_q    (lat_q)
);

// File: tb/qpl_latch_reader_tb_top.sv
module qpl_latch_reader_tb_top;

  localparam int CLK_T = 10;
  localparam int NVEC  = 8;

  logic            clk = 1'b0;
  logic [1:0]      rst_n;
  logic [1:0][31:0] cnt;
  logic            oe_n;
  logic            sel_a, sel_b;
  logic [0:0]      axis_sel;
  logic [7:0]      rd_data;
  logic            rd_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  qpl_latch_reader dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_pos(cnt), .oe_n(oe_n),
    .sel_a(sel_a), .sel_b(sel_b), .axis_sel(axis_sel),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  // {cnt first axis, cnt second axis, axis, sel_a, sel_b}
  localparam logic [66:0] VEC [NVEC] = '{
    {32'h12345678, 32'h9ABCDEF0, 1'b0, 2'b01},
    {32'h12345678, 32'h9ABCDEF0, 1'b0, 2'b11},
    {32'h0F1E2D3C, 32'h4B5A6978, 1'b0, 2'b00},
    {32'h0F1E2D3C, 32'h4B5A6978, 1'b0, 2'b10},
    {32'hDEADBEEF, 32'hCAFEF00D, 1'b1, 2'b01},
    {32'hDEADBEEF, 32'hCAFEF00D, 1'b1, 2'b11},
    {32'h00000001, 32'hFFFFFFFF, 1'b1, 2'b00},
    {32'h00000001, 32'h80000000, 1'b1, 2'b10}
  };

  function automatic logic [7:0] want(input logic [31:0] w, input logic [1:0] code);
    case (code)
      2'b01: return w[31:24];
      2'b11: return w[23:16];
      2'b00: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic oe, input logic [1:0] code, input logic ax);
    oe_n = oe; {sel_a, sel_b} = code; axis_sel = ax;
  endtask

  initial begin
    #(CLK_T * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 2'b00; cnt = '0;
    cnt[0] = 32'h55AA55AA; cnt[1] = 32'hAA55AA55;
    drive(1'b1, 2'b01, 1'b0);
    tick; tick;
    // R1: held in reset, both axes read zero
    chk("R1", rd_data, 8'h00);
    axis_sel = 1'b1; #1;
    chk("R1", rd_data, 8'h00);
    // R8: drive enable follows oe_n
    chk("R8", {7'd0, rd_drive}, 8'h00);
    oe_n = 1'b0; #1;
    chk("R8", {7'd0, rd_drive}, 8'h01);
    oe_n = 1'b1;
    @(negedge clk); rst_n = 2'b11;

    // R2 / R3: tracking mode table
    for (int v = 0; v < NVEC; v++) begin
      @(posedge clk); #2;
      cnt[0] = VEC[v][66:35]; cnt[1] = VEC[v][34:3];
      drive(1'b1, VEC[v][1:0], VEC[v][2]);
      tick;
      chk("R2/R3", rd_data, want(VEC[v][2] ? VEC[v][34:3] : VEC[v][66:35], VEC[v][1:0]));
    end

    // R4 / R5 / R10: coherent read of the first axis
    #1;
    cnt[0] = 32'hA1B2C3D4; cnt[1] = 32'h01020304;
    drive(1'b1, 2'b01, 1'b0);
    tick;
    drive(1'b0, 2'b01, 1'b0);
    tick;
    chk("R4", rd_data, 8'hA1);
    chk("R8", {7'd0, rd_drive}, 8'h01);
    #1; cnt[0] = 32'h11223344; cnt[1] = 32'h55667788;
    sel_a = 1'b1; sel_b = 1'b1; tick;
    chk("R4", rd_data, 8'hB2);
    #1; sel_a = 1'b0; sel_b = 1'b0; tick;
    chk("R4", rd_data, 8'hC3);
    #1; sel_a = 1'b1; sel_b = 1'b0; tick;
    chk("R4", rd_data, 8'hD4);
    #1; axis_sel = 1'b1; sel_a = 1'b1; sel_b = 1'b1; tick;
    chk("R5", rd_data, 8'h66);
    #1; axis_sel = 1'b0; sel_a = 1'b0; sel_b = 1'b1; #1;
    chk("R8", rd_data, 8'hA1);
    tick;
    chk("R10", rd_data, 8'hA1);

    // R6: release, then fresh load
    #1; oe_n = 1'b1; tick;
    chk("R6", rd_data, 8'h11);
    chk("R6", {7'd0, rd_drive}, 8'h00);

    // R7: enable low with non-MSB code keeps tracking
    #1; drive(1'b0, 2'b11, 1'b0); cnt[0] = 32'h00990000; tick; tick;
    chk("R7", rd_data, 8'h99);
    #1; cnt[0] = 32'h00770000; tick;
    chk("R7", rd_data, 8'h77);

    // R9: reset of one axis during a frozen read
    #1; oe_n = 1'b1; cnt[0] = 32'hCCDDEEFF; cnt[1] = 32'h13579BDF; tick;
    #1; drive(1'b0, 2'b01, 1'b0); tick;
    #1; cnt[0] = 32'h24680ACE; oe_n = 1'b1; #1;
    rst_n[0] = 1'b0; #1;
    chk("R9", rd_data, 8'h00);
    axis_sel = 1'b1; #1;
    chk("R9", rd_data, 8'h13);
    axis_sel = 1'b0;
    @(negedge clk); #1; rst_n[0] = 1'b1;
    tick;
    chk("R9", rd_data, 8'h24);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule